// File: doc/BRIEF.md
# Disable-Aware Register Front End for a Serial-Flash Controller

This block sits between a simple slave bus and the rest of a serial-flash controller. It decodes word accesses into a live status view, a set of sticky interrupt/DMA flags, a transfer-count register, a FIFO flush control word and a transmit push port. Before any decoding, the address, byte enables, direction, write data and access strobe are ANDed with the module-enable line. Bus traffic aimed at other modules therefore never toggles the decode logic.

While the controller is in its low-power disable state (`mdis` high), reads still return true values. Every state-changing access is dropped without a response error: flag clears, count writes, flush requests and FIFO pushes. A flash command or a memory-mapped read request that arrives in this window is illegal. It is discarded and reported by a one-cycle error pulse. Outside that window, a programmed flash command is held in a single pending bit. It is released only when the serial-side clock reports ready, so after wake-up the first command waits as long as that clock takes to return.

The transmit push port is valid/ready. A push holds `txf_valid` with `txf_data` until the FIFO raises `txf_ready`. Until then `bus_ready` stays low, and the bus master must keep its access stable. All other accesses complete in the cycle they are presented.

Top module: `sfc_regfront`

## Requirements
- R1: After synchronous active-high reset the flags and transfer count are zero, no command is pending, and `cmd_start` and `cmd_err` are low.
- R2: Reads at byte address 0x00 return `stat_in` zero-extended. Reads at 0x04 return the flags, and reads at 0x08 return the count. Addresses 0x0C, 0x10, any other address and any misaligned address read as zero. `bus_rdata` is zero when no read is presented.
- R3: Each `flag_set` bit sets its flag from the next cycle on. A write to 0x04 with `bus_be[0]` high clears every flag whose bit is one in `bus_wdata[3:0]`. A set and a clear of the same bit in one cycle leave the bit set.
- R4: A write to 0x08 updates count bits 7:0 when `bus_be[0]` is high and bits 15:8 when `bus_be[1]` is high. The new value is visible from the next cycle.
- R5: A write to 0x0C with `bus_be[0]` high drives `flush_tx` from `bus_wdata[0]` and `flush_rx` from `bus_wdata[1]` during that access cycle only.
- R6: A write to 0x10 with all four byte enables high drives `txf_valid` high and `txf_data` equal to `bus_wdata`. While this happens, `bus_ready` equals `txf_ready`. In every other case `bus_ready` is high.
- R7: While `mdis` is high, flag clears, count writes, flush requests and pushes have no effect (`txf_valid` low, `bus_ready` high). Reads still return current values, and `flag_set` still sets flags.
- R8: While `mod_en` is low, a bus access has no effect: `bus_rdata` is zero and `txf_valid`, `flush_tx` and `flush_rx` are low.
- R9: `cmd_req` with `mdis` low marks a command pending. `cmd_start` pulses for one cycle in the first cycle that the command is pending, `mdis` is low and `clk_ready` is high. This happens one or more cycles after the request.
- R10: `cmd_req` or `mem_rd_req` while `mdis` is high is dropped: no pending command, `mem_rd_go` low. `cmd_err` is high in the following cycle.
- R11: `mem_rd_go` follows `mem_rd_req` in the same cycle while `mdis` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_en | input | 1 | Module enable; gates all bus inputs |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address |
| bus_be | input | 4 | Byte enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| bus_ready | output | 1 | Access completes this cycle |
| mdis | input | 1 | Module disable in force |
| stat_in | input | 8 | Live status from the serial engine |
| flag_set | input | 4 | Flag set pulses from the serial engine |
| txf_valid | output | 1 | Push word offered to the TX FIFO |
| txf_data | output | 32 | Push word |
| txf_ready | input | 1 | TX FIFO accepts the word |
| flush_tx | output | 1 | TX FIFO flush pulse |
| flush_rx | output | 1 | RX FIFO flush pulse |
| cmd_req | input | 1 | New flash command programmed |
| mem_rd_req | input | 1 | New memory-mapped read request |
| clk_ready | input | 1 | Serial-side clock available |
| cmd_start | output | 1 | Command start pulse to the serial engine |
| mem_rd_go | output | 1 | Forwarded memory-mapped read request |
| cmd_err | output | 1 | Illegal request pulse |

## Verification
Two pairs of functions can act in the same cycle. In the first, a `flag_set` pulse arrives in the same cycle as a write-one-to-clear of that flag. The bench sweeps every clear mask, with flags preset, in both the enabled and the disabled state. It expects the preset mask minus the cleared bits, or the mask unchanged when disabled, and finally it drives a set and a clear onto the same bit at once and expects the bit to stay set. In the second, `cmd_req` meets a disable window. The bench raises a command with the serial clock down and then enters disable. It checks that no start appears while disabled, even with the clock ready, and that exactly one start follows the exit.

// File: rtl/sfc_regfront_pkg.sv
package sfc_regfront_pkg;
  localparam int OFF_STATUS = 'h00;
  localparam int OFF_FLAGS  = 'h04;
  localparam int OFF_COUNT  = 'h08;
  localparam int OFF_CTRL   = 'h0C;
  localparam int OFF_PUSH   = 'h10;
  localparam int CTRL_FLUSH_TX_BIT = 0;
  localparam int CTRL_FLUSH_RX_BIT = 1;
endpackage

// File: rtl/sfc_bus_gate.sv
module sfc_bus_gate #(
  parameter int AW = 5,
  parameter int DW = 32
) (
  input  logic            mod_en,
  input  logic            in_valid,
  input  logic            in_write,
  input  logic [AW-1:0]   in_addr,
  input  logic [DW/8-1:0] in_be,
  input  logic [DW-1:0]   in_wdata,
  output logic            g_valid,
  output logic            g_write,
  output logic [AW-1:0]   g_addr,
  output logic [DW/8-1:0] g_be,
  output logic [DW-1:0]   g_wdata
);
  localparam int BW = DW / 8;

  always_comb begin
    g_valid = in_valid & mod_en;
    g_write = in_write & mod_en;
    g_addr  = in_addr  & {AW{mod_en}};
    g_be    = in_be    & {BW{mod_en}};
    g_wdata = in_wdata & {DW{mod_en}};
  end
endmodule

// File: rtl/sfc_reg_bank.sv
module sfc_reg_bank
  import sfc_regfront_pkg::*;
#(
  parameter int AW     = 5,
  parameter int DW     = 32,
  parameter int STAT_W = 8,
  parameter int FLAG_W = 4,
  parameter int CNT_W  = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mdis,
  input  logic            acc_valid,
  input  logic            acc_write,
  input  logic [AW-1:0]   acc_addr,
  input  logic [DW/8-1:0] acc_be,
  input  logic [DW-1:0]   acc_wdata,
  output logic [DW-1:0]   rdata,
  output logic            bus_ready,
  input  logic [STAT_W-1:0] stat_in,
  input  logic [FLAG_W-1:0] flag_set,
  output logic            txf_valid,
  output logic [DW-1:0]   txf_data,
  input  logic            txf_ready,
  output logic            flush_tx,
  output logic            flush_rx
);
  localparam int BW = DW / 8;
  localparam int NB = CNT_W / 8;

  logic [FLAG_W-1:0] flags_q, flag_clr;
  logic [CNT_W-1:0]  cnt_q;
  logic wr_ok, rd_ok;
  logic sel_stat, sel_flag, sel_cnt, sel_ctrl, sel_push;

  always_comb begin
    sel_stat = acc_addr == AW'(OFF_STATUS);
    sel_flag = acc_addr == AW'(OFF_FLAGS);
    sel_cnt  = acc_addr == AW'(OFF_COUNT);
    sel_ctrl = acc_addr == AW'(OFF_CTRL);
    sel_push = acc_addr == AW'(OFF_PUSH);
    wr_ok    = acc_valid & acc_write & ~mdis;
    rd_ok    = acc_valid & ~acc_write;
    flag_clr = (wr_ok & sel_flag & acc_be[0]) ? acc_wdata[FLAG_W-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= (flags_q & ~flag_clr) | flag_set;
  end

  for (genvar b = 0; b < NB; b++) begin : g_cnt_byte
    always_ff @(posedge clk) begin
      if (rst)
        cnt_q[8*b +: 8] <= '0;
      else if (wr_ok & sel_cnt & acc_be[b])
        cnt_q[8*b +: 8] <= acc_wdata[8*b +: 8];
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_ok) begin
      if (sel_stat)      rdata = DW'(stat_in);
      else if (sel_flag) rdata = DW'(flags_q);
      else if (sel_cnt)  rdata = DW'(cnt_q);
    end
  end

  always_comb begin
    flush_tx  = wr_ok & sel_ctrl & acc_be[0] & acc_wdata[CTRL_FLUSH_TX_BIT];
    flush_rx  = wr_ok & sel_ctrl & acc_be[0] & acc_wdata[CTRL_FLUSH_RX_BIT];
    txf_valid = wr_ok & sel_push & (&acc_be[BW-1:0]);
    txf_data  = acc_wdata;
    bus_ready = ~txf_valid | txf_ready;
  end

  assert_flags_kept_R7: assert property (@(posedge clk) disable iff (rst)
    mdis |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
  assert_count_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    mdis |=> $stable(cnt_q));
  assert_push_blocked_R7: assert property (@(posedge clk) disable iff (rst)
    mdis |-> (!txf_valid && bus_ready && !flush_tx && !flush_rx));
  assert_set_wins_R3: assert property (@(posedge clk) disable iff (rst)
    (flag_set != '0) |=> ((flags_q & $past(flag_set)) == $past(flag_set)));
endmodule

// File: rtl/sfc_cmd_defer.sv
module sfc_cmd_defer (
  input  logic clk,
  input  logic rst,
  input  logic mdis,
  input  logic clk_ready,
  input  logic cmd_req,
  input  logic mem_rd_req,
  output logic cmd_start,
  output logic mem_rd_go,
  output logic cmd_err
);
  logic pend_q, err_q;

  always_comb begin
    cmd_start = pend_q & ~mdis & clk_ready;
    mem_rd_go = mem_rd_req & ~mdis;
    cmd_err   = err_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      pend_q <= (pend_q & ~cmd_start) | (cmd_req & ~mdis);
      err_q  <= mdis & (cmd_req | mem_rd_req);
    end
  end

  assert_start_gated_R9: assert property (@(posedge clk) disable iff (rst)
    cmd_start |-> (clk_ready && !mdis));
  assert_err_follows_R10: assert property (@(posedge clk) disable iff (rst)
    (mdis && (cmd_req || mem_rd_req)) |=> cmd_err);
  assert_no_fwd_R10: assert property (@(posedge clk) disable iff (rst)
    mdis |-> !mem_rd_go);
endmodule

// File: rtl/sfc_regfront.sv
module sfc_regfront #(
  parameter int AW     = 5,
  parameter int DW     = 32,
  parameter int STAT_W = 8,
  parameter int FLAG_W = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mod_en,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW/8-1:0]   bus_be,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              bus_ready,
  input  logic              mdis,
  input  logic [STAT_W-1:0] stat_in,
  input  logic [FLAG_W-1:0] flag_set,
  output logic              txf_valid,
  output logic [DW-1:0]     txf_data,
  input  logic              txf_ready,
  output logic              flush_tx,
  output logic              flush_rx,
  input  logic              cmd_req,
  input  logic              mem_rd_req,
  input  logic              clk_ready,
  output logic              cmd_start,
  output logic              mem_rd_go,
  output logic              cmd_err
);
  logic            g_valid, g_write;
  logic [AW-1:0]   g_addr;
  logic [DW/8-1:0] g_be;
  logic [DW-1:0]   g_wdata;

  sfc_bus_gate #(.AW(AW), .DW(DW)) u_gate (
    .mod_en(mod_en), .in_valid(bus_valid), .in_write(bus_write),
    .in_addr(bus_addr), .in_be(bus_be), .in_wdata(bus_wdata),
    .g_valid(g_valid), .g_write(g_write), .g_addr(g_addr),
    .g_be(g_be), .g_wdata(g_wdata)
  );

  sfc_reg_bank #(.AW(AW), .DW(DW), .STAT_W(STAT_W), .FLAG_W(FLAG_W), .CNT_W(CNT_W)) u_bank (
    .clk(clk), .rst(rst), .mdis(mdis),
    .acc_valid(g_valid), .acc_write(g_write), .acc_addr(g_addr),
    .acc_be(g_be), .acc_wdata(g_wdata),
    .rdata(bus_rdata), .bus_ready(bus_ready),
    .stat_in(stat_in), .flag_set(flag_set),
    .txf_valid(txf_valid), .txf_data(txf_data), .txf_ready(txf_ready),
    .flush_tx(flush_tx), .flush_rx(flush_rx)
  );

  sfc_cmd_defer u_defer (
    .clk(clk), .rst(rst), .mdis(mdis), .clk_ready(clk_ready),
    .cmd_req(cmd_req), .mem_rd_req(mem_rd_req),
    .cmd_start(cmd_start), .mem_rd_go(mem_rd_go), .cmd_err(cmd_err)
  );

  assert_gated_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !mod_en |-> (bus_rdata == '0 && !txf_valid && !flush_tx && !flush_rx));
endmodule

// File: tb/test_sfc_regfront.sv
module test_sfc_regfront;
  logic clk = 1'b0, rst = 1'b1;
  logic mod_en = 1'b1, bus_valid = 1'b0, bus_write = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [3:0] bus_be = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, txf_data;
  logic bus_ready, mdis = 1'b0;
  logic [7:0] stat_in = '0;
  logic [3:0] flag_set = '0;
  logic txf_valid, txf_ready = 1'b0, flush_tx, flush_rx;
  logic cmd_req = 1'b0, mem_rd_req = 1'b0, clk_ready = 1'b0;
  logic cmd_start, mem_rd_go, cmd_err;
  int n_chk = 0, n_bad = 0, starts = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sfc_regfront i_sfc_regfront (
    .clk(clk), .rst(rst), .mod_en(mod_en), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .mdis(mdis), .stat_in(stat_in), .flag_set(flag_set),
    .txf_valid(txf_valid), .txf_data(txf_data), .txf_ready(txf_ready),
    .flush_tx(flush_tx), .flush_rx(flush_rx), .cmd_req(cmd_req), .mem_rd_req(mem_rd_req),
    .clk_ready(clk_ready), .cmd_start(cmd_start), .mem_rd_go(mem_rd_go), .cmd_err(cmd_err)
  );

  always @(posedge clk) if (!rst && cmd_start) starts++;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [3:0] be, logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_be = 4'hF;
    #1 d = bus_rdata;
    bus_valid = 1'b0;
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    #1500000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(5'h04, r); chk("R1 flags", r, 0);
    rd(5'h08, r); chk("R1 count", r, 0);
    chk("R1 start", {30'b0, cmd_start, cmd_err}, 0);
    chk("R2 idle rdata", bus_rdata, 0);

    // R2 status live, R7 true while disabled
    for (int i = 0; i < 8; i++) begin
      stat_in = 8'(i * 37 + 5); mdis = i[0];
      rd(5'h00, r); chk("R2 R7 status", r, 32'(stat_in));
    end
    mdis = 1'b0;
    for (int a = 9; a < 32; a++) begin
      if (a == 5'h00 || a == 5'h04 || a == 5'h08) continue;
      rd(5'(a), r); chk("R2 zero addr", r, 0);
    end

    // R4 / R7 count byte-enable sweep
    for (int md = 0; md < 2; md++)
      for (int be = 0; be < 16; be++) begin
        wr(5'h08, 4'h3, 32'h0);
        mdis = md[0];
        wr(5'h08, 4'(be), 32'h1234A5C3);
        rd(5'h08, r);
        chk("R4 R7 count", r, md ? 0 : ((be & 1) ? 32'hC3 : 0) | ((be & 2) ? 32'hA500 : 0));
        mdis = 1'b0;
      end

    // R3 / R7 flag clear sweep
    for (int md = 0; md < 2; md++)
      for (int c = 0; c < 16; c++) begin
        flag_set = 4'hF; tick(); flag_set = 4'h0;
        mdis = md[0];
        wr(5'h04, 4'h1, 32'(c));
        rd(5'h04, r);
        chk("R3 R7 flags", r, md ? 32'hF : 32'(4'hF & ~4'(c)));
        mdis = 1'b0;
      end
    wr(5'h04, 4'hE, 32'hF); rd(5'h04, r); chk("R3 clear needs be0", r, 32'hF);
    flag_set = 4'h2; bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 5'h04;
    bus_be = 4'h1; bus_wdata = 32'hF; tick();
    bus_valid = 1'b0; bus_write = 1'b0; flag_set = 4'h0;
    rd(5'h04, r); chk("R3 set wins", r, 32'h2);
    mdis = 1'b1; flag_set = 4'h8; tick(); flag_set = 4'h0;
    rd(5'h04, r); chk("R7 set while disabled", r, 32'hA); mdis = 1'b0;

    // R5 / R7 flush
    for (int md = 0; md < 2; md++)
      for (int v = 0; v < 4; v++) begin
        mdis = md[0];
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 5'h0C; bus_be = 4'h1; bus_wdata = 32'(v);
        #1 chk("R5 R7 flush", {30'b0, flush_rx, flush_tx}, md ? 0 : 32'(v));
        tick(); bus_valid = 1'b0; bus_write = 1'b0;
        #1 chk("R5 pulse ends", {30'b0, flush_rx, flush_tx}, 0);
        mdis = 1'b0;
      end

    // R6 / R7 push handshake
    for (int md = 0; md < 2; md++)
      for (int rdy = 0; rdy < 2; rdy++)
        for (int be = 14; be < 16; be++) begin
          mdis = md[0]; txf_ready = rdy[0];
          bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 5'h10; bus_be = 4'(be);
          bus_wdata = 32'hC0DE0000 + 32'(be);
          #1;
          chk("R6 R7 txf_valid", {31'b0, txf_valid}, (!md && be == 15) ? 1 : 0);
          chk("R6 R7 ready", {31'b0, bus_ready}, (!md && be == 15) ? 32'(rdy) : 1);
          if (txf_valid) chk("R6 data", txf_data, 32'hC0DE000F);
          tick(); bus_valid = 1'b0; bus_write = 1'b0; mdis = 1'b0;
        end

    // R8 gating by module enable
    wr(5'h08, 4'h3, 32'h0055);
    mod_en = 1'b0;
    wr(5'h08, 4'hF, 32'h1234);
    rd(5'h08, r); chk("R8 gated read", r, 0);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 5'h10; bus_be = 4'hF; bus_wdata = 32'h3;
    #1 chk("R8 gated push", {29'b0, txf_valid, flush_tx, flush_rx}, 0);
    tick(); bus_valid = 1'b0; bus_write = 1'b0;
    mod_en = 1'b1;
    rd(5'h08, r); chk("R8 count kept", r, 32'h55);

    // R9 deferred start
    starts = 0; clk_ready = 1'b0;
    cmd_req = 1'b1; #1 chk("R9 not same cycle", {31'b0, cmd_start}, 0);
    tick(); cmd_req = 1'b0;
    repeat (4) tick();
    chk("R9 held", 32'(starts), 0);
    clk_ready = 1'b1; #1 chk("R9 start", {31'b0, cmd_start}, 1);
    repeat (3) tick();
    chk("R9 single pulse", 32'(starts), 1);

    // R9 / R10 pending across disable
    starts = 0; clk_ready = 1'b0;
    cmd_req = 1'b1; tick(); cmd_req = 1'b0;
    mdis = 1'b1; clk_ready = 1'b1; repeat (3) tick();
    chk("R9 no start disabled", 32'(starts), 0);
    mdis = 1'b0; repeat (2) tick();
    chk("R9 start after exit", 32'(starts), 1);

    // R10 illegal requests, R11 forward
    starts = 0; mdis = 1'b1;
    cmd_req = 1'b1; mem_rd_req = 1'b1;
    #1 chk("R10 no forward", {31'b0, mem_rd_go}, 0);
    tick(); cmd_req = 1'b0; mem_rd_req = 1'b0;
    #1 chk("R10 err pulse", {31'b0, cmd_err}, 1);
    tick(); chk("R10 err one cycle", {31'b0, cmd_err}, 0);
    mdis = 1'b0; repeat (3) tick();
    chk("R10 dropped", 32'(starts), 0);
    mem_rd_req = 1'b1; #1 chk("R11 forward", {31'b0, mem_rd_go}, 1);
    tick(); mem_rd_req = 1'b0;
    chk("R11 no err", {31'b0, cmd_err}, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule